// File: doc/BRIEF.md
# Buffered SPI Master Controller

This block is a serial peripheral interface master with a small register file on a synchronous read/write port. Software configures the serial clock divider, word length, bit order, clock polarity and clock phase through a control word. It drives each slave-select line directly through a flag register. A word written into the transmit holding register is shifted out on `mosi`, while the same number of bits is sampled from `miso`.

The holding registers are separate from the shift engine. When a transfer finishes, the received word is moved into the receive holding register and the transmit holding register becomes empty. An interrupt stays raised for as long as the controller is enabled and the transmit holding register is empty. The status word carries live flags and two sticky error flags that are cleared by writing one. Two start modes exist. In one, a transmit write starts the transfer. In the other, a receive-register read starts it, and a fill rule then decides what goes out when nothing new was written.

Top module: `spi_host_ctrl`

Register offsets on `bus_addr`:
- 0: control
- 1: flag
- 2: status
- 3: transmit holding register
- 4: receive holding register
- 5: divider

Control bits:
- [0]: enable
- [1]: clock polarity
- [2]: clock phase
- [3]: word length, 1 = 16 bits, 0 = 8 bits
- [4]: LSB first
- [5]: zero fill
- [6]: overwrite receive data when full
- [8:7]: start mode, 01 = start on transmit write, 00 = start on receive read

Status bits:
- [0]: idle
- [1]: receive full
- [2]: transmit full
- [3]: overrun (sticky)
- [4]: underrun (sticky)

Flag register: bits [NSS-1:0] enable the slave-select lines, and bits [8+NSS-1:8] set their levels.

## Requirements
- R1: Each half period of `sclk` lasts max(D,2) clock cycles, where D is the divider register (offset 5), so the serial clock period is 2*max(D,2) cycles.
- R2: With start mode 01 and enable set, a write to offset 3 starts a transfer once the shift engine is idle, sending that word.
- R3: `irq` is high exactly when enable is 1 and the transmit holding register is empty. It therefore rises right after enable with nothing written, and it drops in the cycle after a write to offset 3.
- R4: Control bit 3 set to 1 gives a 16-bit transfer (16 `sclk` cycles). Set to 0, it gives an 8-bit transfer using data bits [7:0], and the received byte reads back zero-extended.
- R5: Control bit 4 set to 0 sends and receives the most significant bit first. Set to 1, it sends and receives the least significant bit first.
- R6: `sclk` rests at the level of control bit 1 when no transfer runs. With phase 0, data is valid before the first edge and is sampled on each leading edge. With phase 1, data changes on leading edges and is sampled on trailing edges.
- R7: At the end of a transfer, the received word goes to offset 4, status bit 1 sets, status bit 2 clears and status bit 0 returns to 1.
- R8: If a transfer ends while the receive holding register is full, status bit 3 sets. With control bit 6 at 0 the new word is dropped; with control bit 6 at 1 it replaces the old one.
- R9: With start mode 00, a read of offset 4 while idle starts a transfer. If the transmit holding register is empty, the transfer sends all zeros when control bit 5 is 1, or repeats the previously sent word when it is 0, and status bit 4 sets.
- R10: For each line n, `ss_en[n]` follows flag bit n and `ss_lvl[n]` follows flag bit 8+n. After reset the enables are 0 and the levels are 1.
- R11: Status reads 0x0001 after reset. Bits 3 and 4 clear only when a 1 is written to them, and writing 0 leaves them set.
- R12: A read of offset 4 clears status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on offset 4) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Transmit-empty interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_en | output | NSS | Slave-select line enables |
| ss_lvl | output | NSS | Slave-select line levels |

## Verification
The bench builds the block with NSS = 3 and BAUD_W = 8. Three lines are enough to set enable and level patterns that differ bit by bit. An 8-bit divider keeps the clamp threshold at 0 and 1, and a divider of 3, quickly reachable, so serial clock periods of 4 and 6 cycles can be timed directly. A bench slave model follows the polarity and phase settings and records what appears on `mosi`. This lets both shift directions, both word lengths and the fill rules for an empty transmit register be checked at the pins.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int DATA_W = 16;
    localparam int HALF_W = DATA_W / 2;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 3'd0,
        REG_FLAG = 3'd1,
        REG_STAT = 3'd2,
        REG_TXB  = 3'd3,
        REG_RXB  = 3'd4,
        REG_BAUD = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        START_ON_RXREAD  = 2'b00,
        START_ON_TXWRITE = 2'b01
    } start_mode_e;

    typedef struct packed {
        start_mode_e start_mode;
        logic        overwrite;
        logic        zero_fill;
        logic        lsb_first;
        logic        wide;
        logic        cpha;
        logic        cpol;
        logic        enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic underrun;
        logic overrun;
        logic tx_full;
        logic rx_full;
        logic idle;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);

    // Reverse the low n bits of w, clearing the rest.
    function automatic logic [DATA_W-1:0] rev_low(input logic [DATA_W-1:0] w, input int n);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < n) r[n-1-i] = w[i];
        end
        return r;
    endfunction

    // Word to shift image: the first bit on the line sits at the top.
    function automatic logic [DATA_W-1:0] to_line(input logic [DATA_W-1:0] w,
                                                  input logic lsb, input logic wide);
        logic [DATA_W-1:0] t;
        int n;
        n = wide ? DATA_W : HALF_W;
        t = wide ? w : {{HALF_W{1'b0}}, w[HALF_W-1:0]};
        if (lsb) t = rev_low(t, n);
        if (!wide) t = t << HALF_W;
        return t;
    endfunction

    // Collected bits (first received at the highest used bit) to a word.
    function automatic logic [DATA_W-1:0] from_line(input logic [DATA_W-1:0] s,
                                                    input logic lsb, input logic wide);
        logic [DATA_W-1:0] t;
        int n;
        n = wide ? DATA_W : HALF_W;
        t = wide ? s : {{HALF_W{1'b0}}, s[HALF_W-1:0]};
        if (lsb) t = rev_low(t, n);
        return t;
    endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int BAUD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [BAUD_W-1:0] divider,
    output logic              tick
);
    localparam logic [BAUD_W-1:0] MIN_HALF = BAUD_W'(2);

    logic [BAUD_W-1:0] half;
    logic [BAUD_W-1:0] cnt;

    assign half = (divider < MIN_HALF) ? MIN_HALF : divider;
    assign tick = run && (cnt == half - BAUD_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + BAUD_W'(1);
    end
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng import spi_host_pkg::*; #(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         tick,
    input  logic         cpha,
    input  logic         wide,
    input  logic [W-1:0] tx_img,
    input  logic         miso,
    output logic         mosi,
    output logic         phase,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rx_word
);
    localparam int EW = $clog2(2 * W);

    logic [W-1:0]  tx_sh;
    logic [W-1:0]  rx_sh;
    logic [EW-1:0] edge_q;
    logic [EW-1:0] last_edge;
    logic          sample_now;

    assign last_edge  = wide ? EW'(2 * W - 1) : EW'(W - 1);
    assign sample_now = (edge_q[0] == cpha);
    assign done       = busy && tick && (edge_q == last_edge);
    assign rx_word    = sample_now ? {rx_sh[W-2:0], miso} : rx_sh;
    assign mosi       = tx_sh[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            phase  <= 1'b0;
            edge_q <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            phase  <= 1'b0;
            edge_q <= '0;
            tx_sh  <= tx_img;
            rx_sh  <= '0;
        end else if (busy && tick) begin
            phase  <= ~phase;
            edge_q <= edge_q + EW'(1);
            if (sample_now)          rx_sh <= {rx_sh[W-2:0], miso};
            else if (edge_q != '0)   tx_sh <= {tx_sh[W-2:0], 1'b0};
            if (edge_q == last_edge) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_ss_drive.sv
module spi_ss_drive import spi_host_pkg::*; #(
    parameter int NSS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NSS-1:0]    ss_en,
    output logic [NSS-1:0]    ss_lvl,
    output logic [DATA_W-1:0] readback
);
    localparam int LVL_OFS = HALF_W;

    for (genvar i = 0; i < NSS; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                ss_en[i]  <= 1'b0;
                ss_lvl[i] <= 1'b1;
            end else if (wr) begin
                ss_en[i]  <= wdata[i];
                ss_lvl[i] <= wdata[LVL_OFS + i];
            end
        end
    end

    always_comb begin
        readback = '0;
        readback[NSS-1:0]               = ss_en;
        readback[LVL_OFS+NSS-1:LVL_OFS] = ss_lvl;
    end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl import spi_host_pkg::*; #(
    parameter int NSS    = 4,
    parameter int BAUD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NSS-1:0]    ss_en,
    output logic [NSS-1:0]    ss_lvl
);
    localparam int OVR_BIT = 3;
    localparam int UND_BIT = 4;

    ctrl_t             ctrl;
    logic [BAUD_W-1:0] divider;
    logic [DATA_W-1:0] txbuf, rxbuf, last_word;
    logic              tx_full, rx_full, ovr, und;

    logic wr_ctrl, wr_flag, wr_stat, wr_txb, wr_baud, rd_rxb;
    logic busy, done, tick, phase, start;
    logic [DATA_W-1:0] pick_word, tx_img, rx_raw, flag_rb;
    stat_t stat;

    assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
    assign wr_flag = bus_wr && (bus_addr == REG_FLAG);
    assign wr_stat = bus_wr && (bus_addr == REG_STAT);
    assign wr_txb  = bus_wr && (bus_addr == REG_TXB);
    assign wr_baud = bus_wr && (bus_addr == REG_BAUD);
    assign rd_rxb  = bus_rd && (bus_addr == REG_RXB);

    always_comb begin
        start = 1'b0;
        if (ctrl.enable && !busy) begin
            case (ctrl.start_mode)
                START_ON_TXWRITE: start = tx_full;
                START_ON_RXREAD:  start = rd_rxb;
                default:          start = 1'b0;
            endcase
        end
    end

    assign pick_word = tx_full ? txbuf : (ctrl.zero_fill ? '0 : last_word);
    assign tx_img    = to_line(pick_word, ctrl.lsb_first, ctrl.wide);

    spi_clk_div #(.BAUD_W(BAUD_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .divider (divider),
        .tick    (tick)
    );

    spi_shift_eng #(.W(DATA_W)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .tick    (tick),
        .cpha    (ctrl.cpha),
        .wide    (ctrl.wide),
        .tx_img  (tx_img),
        .miso    (miso),
        .mosi    (mosi),
        .phase   (phase),
        .busy    (busy),
        .done    (done),
        .rx_word (rx_raw)
    );

    spi_ss_drive #(.NSS(NSS)) u_ss (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_flag),
        .wdata    (bus_wdata),
        .ss_en    (ss_en),
        .ss_lvl   (ss_lvl),
        .readback (flag_rb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            divider   <= '0;
            txbuf     <= '0;
            rxbuf     <= '0;
            last_word <= '0;
            tx_full   <= 1'b0;
            rx_full   <= 1'b0;
            ovr       <= 1'b0;
            und       <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl    <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_baud) divider <= bus_wdata[BAUD_W-1:0];
            if (wr_stat) begin
                if (bus_wdata[OVR_BIT]) ovr <= 1'b0;
                if (bus_wdata[UND_BIT]) und <= 1'b0;
            end
            if (rd_rxb) rx_full <= 1'b0;
            if (start) begin
                last_word <= pick_word;
                if (!tx_full) und <= 1'b1;
            end
            if (done) begin
                if (!rx_full || ctrl.overwrite)
                    rxbuf <= from_line(rx_raw, ctrl.lsb_first, ctrl.wide);
                if (rx_full) ovr <= 1'b1;
                rx_full <= 1'b1;
                tx_full <= 1'b0;
            end
            if (wr_txb) begin
                txbuf   <= bus_wdata;
                tx_full <= 1'b1;
            end
        end
    end

    assign stat = '{underrun: und, overrun: ovr, tx_full: tx_full,
                    rx_full: rx_full, idle: !busy};

    always_comb begin
        case (bus_addr)
            REG_CTRL: bus_rdata = DATA_W'(ctrl);
            REG_FLAG: bus_rdata = flag_rb;
            REG_STAT: bus_rdata = DATA_W'(stat);
            REG_TXB:  bus_rdata = txbuf;
            REG_RXB:  bus_rdata = rxbuf;
            REG_BAUD: bus_rdata = DATA_W'(divider);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq  = ctrl.enable && !tx_full;
    assign sclk = ctrl.cpol ^ phase;
endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       sclk,
    input logic       cpol,
    input logic       en,
    input logic       busy,
    input logic       irq,
    input logic       rx_full,
    input logic       ovr,
    input logic       bus_wr,
    input logic [2:0] bus_addr
);
    // R3: a transmit write removes the interrupt request on the next cycle
    assert_irq_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd3 && en) |=> !irq);

    // R6: serial clock rests at the polarity level between transfers
    assert_sclk_rest_R6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == cpol));

    // R1: a serial clock level lasts at least two cycles during a transfer
    assert_min_half_R1: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (sclk != $past(sclk))) |=> $stable(sclk));

    // R7: a finished transfer leaves the receive register full
    assert_done_full_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rx_full);

    // R8: overrun is only raised as a transfer ends
    assert_ovr_at_end_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $fell(busy));
endmodule

bind spi_host_ctrl spi_host_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk),
    .cpol     (ctrl.cpol),
    .en       (ctrl.enable),
    .busy     (busy),
    .irq      (irq),
    .rx_full  (rx_full),
    .ovr      (ovr),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr)
);

// File: tb/sim_spi_host_ctrl.sv
`timescale 1ns/1ps
module sim_spi_host_ctrl;
    localparam int NSS    = 3;
    localparam int BAUD_W = 8;

    localparam logic [15:0] C_EN   = 16'h0001;
    localparam logic [15:0] C_CPOL = 16'h0002;
    localparam logic [15:0] C_CPHA = 16'h0004;
    localparam logic [15:0] C_WIDE = 16'h0008;
    localparam logic [15:0] C_LSB  = 16'h0010;
    localparam logic [15:0] C_ZERO = 16'h0020;
    localparam logic [15:0] C_OVWR = 16'h0040;
    localparam logic [15:0] C_TXM  = 16'h0080;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, sclk, mosi;
    logic        miso = 1'b0;
    logic [NSS-1:0] ss_en, ss_lvl;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    spi_host_ctrl #(.NSS(NSS), .BAUD_W(BAUD_W)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso),
        .ss_en(ss_en), .ss_lvl(ss_lvl)
    );

    // Slave model
    logic        slv_on = 1'b0, slv_cpol = 1'b0, slv_cpha = 1'b0, slv_lsb = 1'b0;
    int          slv_n = 16, idx = 0, nlead = 0;
    logic [15:0] slv_word = '0, cap = '0;

    function automatic logic sbit(input int i);
        if (i >= slv_n) return 1'b0;
        return slv_lsb ? slv_word[i] : slv_word[slv_n-1-i];
    endfunction

    function automatic logic [15:0] exp_line(input logic [15:0] w, input int n, input logic lsb);
        logic [15:0] r;
        r = '0;
        for (int i = 0; i < n; i++) r = {r[14:0], (lsb ? w[i] : w[n-1-i])};
        return r;
    endfunction

    always @(sclk) begin
        if (slv_on) begin
            if (sclk != slv_cpol) nlead++;
            if ((sclk != slv_cpol) != slv_cpha) cap = {cap[14:0], mosi};
            else if (slv_cpha) begin miso = sbit(idx); idx++; end
            else begin idx++; miso = sbit(idx); end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic arm(input logic cpol, input logic cpha, input logic lsb, input int n,
                       input logic [15:0] w);
        slv_cpol = cpol; slv_cpha = cpha; slv_lsb = lsb; slv_n = n; slv_word = w;
        idx = 0; nlead = 0; cap = '0;
        miso = cpha ? 1'b0 : sbit(0);
        slv_on = 1'b1;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 2000; k++) begin
            rd(3'd2, s);
            if (s[0]) break;
        end
        slv_on = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(3'd2, v); chk("R11 status after reset", v, 16'h0001);
        chk("R3 irq low while disabled", irq, 1'b0);
        chk("R6 sclk idle after reset", sclk, 1'b0);
        chk("R10 ss_en after reset", ss_en, 3'b000);
        chk("R10 ss_lvl after reset", ss_lvl, 3'b111);
    endtask

    task automatic t_wide_msb();
        logic [15:0] v;
        wr(3'd5, 16'd2);
        wr(3'd0, C_EN | C_TXM | C_WIDE);
        @(negedge clk); chk("R3 irq on enable with empty tx", irq, 1'b1);
        arm(1'b0, 1'b0, 1'b0, 16, 16'hC3A5);
        wr(3'd3, 16'h9A5C);
        chk("R3 irq cleared by tx write", irq, 1'b0);
        wait_idle();
        chk("R2 R5 mosi msb-first word", cap, exp_line(16'h9A5C, 16, 1'b0));
        chk("R4 16 clocks in wide mode", nlead, 16);
        rd(3'd2, v); chk("R7 status after transfer", v, 16'h0003);
        chk("R7 irq after tx emptied", irq, 1'b1);
        rd(3'd4, v); chk("R7 received word", v, 16'hC3A5);
        rd(3'd2, v); chk("R12 rx read clears full", v, 16'h0001);
    endtask

    task automatic t_byte_lsb();
        logic [15:0] v;
        wr(3'd0, C_EN | C_TXM | C_CPOL | C_CPHA | C_LSB);
        @(negedge clk); chk("R6 sclk idles high with cpol", sclk, 1'b1);
        arm(1'b1, 1'b1, 1'b1, 8, 16'h006E);
        wr(3'd3, 16'h12D3);
        wait_idle();
        chk("R5 R6 mosi lsb-first byte", cap[7:0], exp_line(16'h00D3, 8, 1'b1));
        chk("R4 8 clocks in byte mode", nlead, 8);
        rd(3'd4, v); chk("R4 R5 received byte", v, 16'h006E);
    endtask

    task automatic t_divider();
        logic [15:0] v;
        realtime t0, t1;
        wr(3'd0, C_EN | C_TXM | C_WIDE);
        wr(3'd5, 16'd0);
        wr(3'd3, 16'h0F0F);
        @(posedge sclk); t0 = $realtime;
        @(posedge sclk); t1 = $realtime;
        chk("R1 divider 0 clamps to period 4", int'((t1 - t0) / 20.0), 4);
        wait_idle(); rd(3'd4, v);
        wr(3'd5, 16'd3);
        wr(3'd3, 16'hF0F0);
        @(posedge sclk); t0 = $realtime;
        @(posedge sclk); t1 = $realtime;
        chk("R1 divider 3 gives period 6", int'((t1 - t0) / 20.0), 6);
        wait_idle(); rd(3'd4, v);
        wr(3'd5, 16'd2);
    endtask

    task automatic t_overrun();
        logic [15:0] v;
        wr(3'd2, 16'h0018);
        wr(3'd0, C_EN | C_TXM | C_CPOL);
        arm(1'b1, 1'b0, 1'b0, 8, 16'h0011); wr(3'd3, 16'h00A1); wait_idle();
        chk("R2 R6 cpol1 cpha0 byte out", cap[7:0], exp_line(16'h00A1, 8, 1'b0));
        arm(1'b1, 1'b0, 1'b0, 8, 16'h0022); wr(3'd3, 16'h00B2); wait_idle();
        rd(3'd2, v); chk("R8 overrun flagged", v, 16'h000B);
        wr(3'd2, 16'h0000);
        rd(3'd2, v); chk("R11 writing 0 keeps sticky bit", v, 16'h000B);
        wr(3'd2, 16'h0008);
        rd(3'd2, v); chk("R11 writing 1 clears sticky bit", v, 16'h0003);
        rd(3'd4, v); chk("R8 new data dropped when full", v, 16'h0011);
        wr(3'd0, C_EN | C_TXM | C_CPOL | C_OVWR);
        arm(1'b1, 1'b0, 1'b0, 8, 16'h0033); wr(3'd3, 16'h00C3); wait_idle();
        arm(1'b1, 1'b0, 1'b0, 8, 16'h0044); wr(3'd3, 16'h00D4); wait_idle();
        rd(3'd4, v); chk("R8 overwrite when enabled", v, 16'h0044);
        wr(3'd2, 16'h0018);
    endtask

    task automatic t_rx_start();
        logic [15:0] v;
        wr(3'd0, C_EN | C_WIDE);
        rd(3'd2, v); chk("R9 precondition tx empty, rx empty", v, 16'h0001);
        arm(1'b0, 1'b0, 1'b0, 16, 16'hBEEF);
        rd(3'd4, v);
        wait_idle();
        chk("R9 repeats last word", cap, exp_line(16'h00D4, 16, 1'b0));
        rd(3'd2, v); chk("R9 underrun flagged", v, 16'h0013);
        wr(3'd0, C_EN | C_WIDE | C_ZERO);
        arm(1'b0, 1'b0, 1'b0, 16, 16'h1234);
        rd(3'd4, v); chk("R9 read returns first result", v, 16'hBEEF);
        wait_idle();
        chk("R9 zero fill", cap, 16'h0000);
        wr(3'd0, C_EN | C_TXM | C_WIDE);
        rd(3'd4, v); chk("R9 second result", v, 16'h1234);
    endtask

    task automatic t_select();
        logic [15:0] v;
        wr(3'd1, 16'h0205);
        @(negedge clk);
        chk("R10 ss_en follows flag", ss_en, 3'b101);
        chk("R10 ss_lvl follows flag", ss_lvl, 3'b010);
        rd(3'd1, v); chk("R10 flag readback", v, 16'h0205);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wide_msb();
        t_byte_lsb();
        t_divider();
        t_overrun();
        t_rx_start();
        t_select();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule